// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Model

This block behaves like a 64 KB serial EEPROM that sits on an SPI bus as a slave. It runs entirely in the system clock domain. The chip-select, serial clock, hold and data-in lines pass through synchronizers, and the block acts on every rising edge of the serial clock.

Each transaction opens with an 8-bit instruction. Array instructions carry a 16-bit address. After the address, an array write collects data bytes and an array read streams bytes back. A status register holds a write-enable latch and a two-bit protect code. The protect code can lock the top quarter of the address space, the top half, or all of it.

The storage is an internal synchronous RAM of `2**MEM_AW` bytes. Every address comparison uses the full 16-bit address: protection, page wrap and read wrap. Only the low `MEM_AW` bits select a RAM cell, so the default build is small and still keeps the full 64 KB address behaviour.

Top module: `spi_ee_slave`

## Requirements
- R1: While `spi_csn` is high and `spi_hold_n` is high, the block drops any command in progress and waits for a new instruction. It clears its bit counter and instruction register and drives `spi_miso` high.
- R2: While `spi_hold_n` is low, every line change is ignored. The state, address, status and `spi_miso` keep their values, and the transfer resumes where it stopped once hold is released.
- R3: Input bits are taken most significant bit first, one per rising edge of `spi_sck`. Output bits change on rising edges of `spi_sck`, also most significant bit first.
- R4: Instruction codes are: 0x01 status write, 0x02 array write, 0x03 array read, 0x04 clear the write-enable latch, 0x05 status read, 0x06 set the write-enable latch. Any other code parks the block with `spi_miso` high until chip select rises.
- R5: An array read or write sends a 16-bit address after the instruction, high byte first. A read then returns the byte at that address, and a write stores the following data bytes. The RAM cell is selected by the low `MEM_AW` address bits.
- R6: A status write takes one byte and copies only its bits 3:2 into the protect code. The write-enable latch (status bit 1) is left as it was. A status read returns {4'b0000, protect[1:0], wel, 1'b0} and repeats that byte for as long as clocking continues.
- R7: An array byte is stored only when the write-enable latch is set and the address is not locked. Protect code 00 locks nothing. Code 01 locks 0xC000-0xFFFF, code 10 locks 0x8000-0xFFFF, and code 11 locks every address.
- R8: After each data byte of an array write, only the low 7 address bits count up, so a burst wraps inside its 128-byte page. The address advances whether or not the byte was stored.
- R9: After each byte of an array read, the address advances by one modulo 65536 (0xFFFF is followed by 0x0000) and the next byte is fetched.
- R10: After reset, `spi_miso` is high, the write-enable latch is clear and the protect code is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the master |
| spi_hold_n | input | 1 | Hold, active low; pauses the transfer |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, idles high |

## Verification
The hardest case to reach is a hold pulse in the middle of an instruction while the serial clock keeps toggling. To show that those edges were dropped, the rest of the command must still complete correctly afterwards. The bench splits a read instruction in half and releases hold between the halves. It toggles the clock with data-in high during the pause, then checks that the byte read back matches its memory model. The protection sweep is the other costly case. Every protect code is crossed with both latch states and one address in each sector, and a baseline is written first so that a blocked write shows up as an unchanged byte.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

   typedef enum logic [2:0] {
      ST_FETCH,
      ST_ADDR,
      ST_SINK,
      ST_SOURCE,
      ST_PARK
   } ee_state_t;

   localparam logic [7:0] CMD_STAT_WR = 8'h01;
   localparam logic [7:0] CMD_ARR_WR  = 8'h02;
   localparam logic [7:0] CMD_ARR_RD  = 8'h03;
   localparam logic [7:0] CMD_WEL_CLR = 8'h04;
   localparam logic [7:0] CMD_STAT_RD = 8'h05;
   localparam logic [7:0] CMD_WEL_SET = 8'h06;

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
   parameter int          WIDTH   = 4,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   initial begin
      assert (STAGES >= 2) else $error("spi_ee_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_ee_ram.sv
module spi_ee_ram #(
   parameter int AW = 10,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
      if (re) rdata <= cells[raddr];
   end

endmodule

// File: rtl/spi_ee_guard.sv
module spi_ee_guard #(
   parameter int ADDR_W = 16
) (
   input  logic              wel,
   input  logic [1:0]        bp,
   input  logic [ADDR_W-1:0] addr,
   output logic              allow
);

   logic lock;

   always_comb begin
      unique case (bp)
         2'b00:   lock = 1'b0;
         2'b01:   lock = &addr[ADDR_W-1 -: 2];
         2'b10:   lock = addr[ADDR_W-1];
         default: lock = 1'b1;
      endcase
      allow = wel & ~lock;
   end

   always_comb begin
      if (bp == 2'b11) p_full_lock_r7: assert (!allow);
      if (!wel)        p_latch_gate_r7: assert (!allow);
   end

endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave
   import spi_ee_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int MEM_AW      = 10,
   parameter int PAGE_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_csn,
   input  logic spi_sck,
   input  logic spi_hold_n,
   input  logic spi_mosi,
   output logic spi_miso
);

   localparam int              CNT_W     = $clog2(ADDR_W);
   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
   localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(7);

   initial begin
      assert (ADDR_W >= 8)       else $error("spi_ee_slave: ADDR_W below 8");
      assert (MEM_AW <= ADDR_W)  else $error("spi_ee_slave: MEM_AW exceeds ADDR_W");
      assert (PAGE_W < MEM_AW)   else $error("spi_ee_slave: PAGE_W must be below MEM_AW");
   end

   // synchronized lines: {csn, sck, hold_n, mosi}
   logic [3:0] lines_s;
   logic       csn_s, sck_s, hold_s, mosi_s;

   spi_ee_sync #(
      .WIDTH  (4),
      .STAGES (SYNC_STAGES),
      .RST_VAL(4'b1010)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({spi_csn, spi_sck, spi_hold_n, spi_mosi}),
      .q    (lines_s)
   );

   assign {csn_s, sck_s, hold_s, mosi_s} = lines_s;

   logic sck_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end

   logic rise, step;
   assign rise = sck_s & ~sck_q;
   assign step = hold_s & ~csn_s & rise;

   ee_state_t         state;
   logic [CNT_W-1:0]  cnt;
   logic [7:0]        opc;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        shreg;
   logic [7:0]        out_byte;
   logic              wel;
   logic [1:0]        bp;
   logic              miso_q;
   logic              load_q;

   logic [7:0]        opc_in, byte_in, stat_byte;
   logic [ADDR_W-1:0] addr_in, addr_inc, page_next;
   logic              last8, allow;

   assign opc_in    = {opc[6:0], mosi_s};
   assign byte_in   = {shreg[6:0], mosi_s};
   assign addr_in   = {addr_q[ADDR_W-2:0], mosi_s};
   assign addr_inc  = addr_q + ADDR_W'(1);
   assign page_next = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
   assign stat_byte = {4'b0000, bp, wel, 1'b0};
   assign last8     = (cnt == BYTE_LAST);

   spi_ee_guard #(.ADDR_W(ADDR_W)) u_guard (
      .wel  (wel),
      .bp   (bp),
      .addr (addr_q),
      .allow(allow)
   );

   logic              ram_we, ram_re;
   logic [MEM_AW-1:0] ram_raddr;
   logic [7:0]        ram_rdata;

   always_comb begin
      ram_we    = 1'b0;
      ram_re    = 1'b0;
      ram_raddr = addr_q[MEM_AW-1:0];
      if (step) begin
         unique case (state)
            ST_ADDR: if (cnt == ADDR_LAST && opc[0]) begin
               ram_re    = 1'b1;
               ram_raddr = addr_in[MEM_AW-1:0];
            end
            ST_SINK: if (last8 && opc == CMD_ARR_WR && allow) ram_we = 1'b1;
            ST_SOURCE: if (last8 && opc == CMD_ARR_RD) begin
               ram_re    = 1'b1;
               ram_raddr = addr_inc[MEM_AW-1:0];
            end
            default: ;
         endcase
      end
   end

   spi_ee_ram #(.AW(MEM_AW), .DW(8)) u_ram (
      .clk  (clk),
      .we   (ram_we),
      .waddr(addr_q[MEM_AW-1:0]),
      .wdata(byte_in),
      .re   (ram_re),
      .raddr(ram_raddr),
      .rdata(ram_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_FETCH;
         cnt      <= '0;
         opc      <= '0;
         addr_q   <= '0;
         shreg    <= '0;
         out_byte <= '0;
         wel      <= 1'b0;
         bp       <= 2'b00;
         miso_q   <= 1'b1;
         load_q   <= 1'b0;
      end else begin
         load_q <= ram_re;
         if (load_q) out_byte <= ram_rdata;
         if (hold_s) begin
            if (csn_s) begin
               state  <= ST_FETCH;
               cnt    <= '0;
               opc    <= '0;
               miso_q <= 1'b1;
            end else if (rise) begin
               unique case (state)
                  ST_FETCH: begin
                     opc <= opc_in;
                     if (last8) begin
                        cnt <= '0;
                        unique case (opc_in)
                           CMD_STAT_WR: begin shreg <= '0; state <= ST_SINK; end
                           CMD_ARR_WR,
                           CMD_ARR_RD:  begin addr_q <= '0; state <= ST_ADDR; end
                           CMD_WEL_CLR: begin wel <= 1'b0; state <= ST_PARK; end
                           CMD_STAT_RD: begin out_byte <= stat_byte; state <= ST_SOURCE; end
                           CMD_WEL_SET: begin wel <= 1'b1; state <= ST_PARK; end
                           default:     state <= ST_PARK;
                        endcase
                     end else begin
                        cnt <= cnt + CNT_W'(1);
                     end
                  end
                  ST_ADDR: begin
                     addr_q <= addr_in;
                     if (cnt == ADDR_LAST) begin
                        cnt <= '0;
                        if (opc[0]) state <= ST_SOURCE;
                        else begin
                           shreg <= '0;
                           state <= ST_SINK;
                        end
                     end else begin
                        cnt <= cnt + CNT_W'(1);
                     end
                  end
                  ST_SINK: begin
                     if (last8) begin
                        cnt   <= '0;
                        shreg <= '0;
                        if (opc == CMD_STAT_WR) begin
                           bp    <= byte_in[3:2];
                           state <= ST_PARK;
                        end else begin
                           addr_q <= page_next;
                        end
                     end else begin
                        shreg <= byte_in;
                        cnt   <= cnt + CNT_W'(1);
                     end
                  end
                  ST_SOURCE: begin
                     miso_q <= out_byte[3'd7 - cnt[2:0]];
                     if (last8) begin
                        cnt <= '0;
                        if (opc == CMD_ARR_RD) addr_q <= addr_inc;
                     end else begin
                        cnt <= cnt + CNT_W'(1);
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   assign spi_miso = miso_q;

   // ---------------- assertions ----------------
   p_cs_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_s && csn_s) |=> (spi_miso && state == ST_FETCH && cnt == '0));

   p_hold_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_s |=> ($stable(state) && $stable(addr_q) && $stable(spi_miso)
                   && $stable(wel) && $stable(bp) && $stable(cnt)));

   p_latch_cmd_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(wel));

   p_park_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PARK) |-> spi_miso);

   p_stat_keeps_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && state == ST_SINK && last8 && opc == CMD_STAT_WR) |=> $stable(wel));

   p_write_in_sink_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (state == ST_SINK && wel));

   p_page_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (step && state == ST_SINK && last8 && opc == CMD_ARR_WR)
      |=> (addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W])));

   p_read_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (step && state == ST_SOURCE && last8 && opc == CMD_ARR_RD)
      |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

   p_counter_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_ADDR) |-> (cnt <= BYTE_LAST));

endmodule

// File: tb/spi_ee_slave_bench.sv
module spi_ee_slave_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic csn = 1'b1, sck = 1'b0, hold_n = 1'b1, mosi = 1'b0;
   logic miso;

   always #5 clk = ~clk;

   spi_ee_slave u_spi_ee_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .spi_csn   (csn),
      .spi_sck   (sck),
      .spi_hold_n(hold_n),
      .spi_mosi  (mosi),
      .spi_miso  (miso)
   );

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] mdl [1024];
   logic       m_wel = 1'b0;
   logic [1:0] m_bp  = 2'b00;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic sbit(input logic b, output logic r);
      mosi = b;
      tick(6);
      sck = 1'b1;
      tick(6);
      r = miso;
      sck = 1'b0;
   endtask

   task automatic xbyte(input logic [7:0] d, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) sbit(d[i], r[i]);
   endtask

   task automatic cs_lo();
      csn = 1'b0;
      tick(4);
   endtask

   task automatic cs_hi();
      tick(4);
      csn = 1'b1;
      tick(6);
   endtask

   function automatic logic locked(input logic [1:0] bp, input logic [15:0] a);
      case (bp)
         2'b01:   return a >= 16'hC000;
         2'b10:   return a >= 16'h8000;
         2'b11:   return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] r;
      cs_lo();
      xbyte(op, r);
      cs_hi();
      if (op == 8'h06) m_wel = 1'b1;
      if (op == 8'h04) m_wel = 1'b0;
   endtask

   task automatic stat_wr(input logic [7:0] v);
      logic [7:0] r;
      cs_lo();
      xbyte(8'h01, r);
      xbyte(v, r);
      cs_hi();
      m_bp = v[3:2];
   endtask

   task automatic stat_rd_chk(input string req);
      logic [7:0] r;
      cs_lo();
      xbyte(8'h05, r);
      for (int i = 0; i < 2; i++) begin
         xbyte(8'h00, r);
         chk(req, r, {4'b0000, m_bp, m_wel, 1'b0});
      end
      cs_hi();
   endtask

   task automatic mem_wr(input logic [15:0] addr, input int n, input logic [7:0] base);
      logic [7:0] r;
      logic [15:0] a;
      cs_lo();
      xbyte(8'h02, r);
      xbyte(addr[15:8], r);
      xbyte(addr[7:0], r);
      for (int i = 0; i < n; i++) begin
         a = (addr & 16'hFF80) | ((addr + 16'(i)) & 16'h007F);
         xbyte(base + 8'(i), r);
         if (m_wel && !locked(m_bp, a)) mdl[a[9:0]] = base + 8'(i);
      end
      cs_hi();
   endtask

   task automatic mem_rd_chk(input logic [15:0] addr, input int n, input string req);
      logic [7:0] r;
      logic [15:0] a;
      cs_lo();
      xbyte(8'h03, r);
      xbyte(addr[15:8], r);
      xbyte(addr[7:0], r);
      for (int i = 0; i < n; i++) begin
         a = addr + 16'(i);
         xbyte(8'h00, r);
         chk(req, r, mdl[a[9:0]]);
      end
      cs_hi();
   endtask

   initial begin
      logic [7:0] r;
      logic       b;
      logic [15:0] pa [3];
      pa[0] = 16'h1010; pa[1] = 16'h9020; pa[2] = 16'hD030;

      tick(3);
      rst_n = 1'b1;
      tick(5);

      // R10: reset state
      chk("R10 miso idle", {7'b0, miso}, 8'h01);
      stat_rd_chk("R10 R6 status after reset");

      // R5 R3: plain write and read back
      cmd1(8'h06);
      stat_rd_chk("R4 latch set");
      mem_wr(16'h0040, 3, 8'hA5);
      mem_rd_chk(16'h0040, 3, "R5 R3 write/read");

      // R4: latch clear blocks writes
      cmd1(8'h04);
      stat_rd_chk("R4 latch cleared");
      mem_wr(16'h0040, 1, 8'h11);
      mem_rd_chk(16'h0040, 1, "R4 R7 write with latch clear");

      // R6: status round trip, latch kept
      cmd1(8'h06);
      stat_wr(8'hFF);
      stat_rd_chk("R6 status write keeps latch");
      stat_wr(8'h00);
      stat_rd_chk("R6 status write back to zero");

      // R7: sweep protect codes x latch x sector
      for (int c = 0; c < 4; c++) begin
         for (int w = 0; w < 2; w++) begin
            stat_wr(8'h00);
            cmd1(8'h06);
            for (int k = 0; k < 3; k++) mem_wr(pa[k], 1, 8'h30 + 8'(k));
            stat_wr({4'b0, 2'(c), 2'b00});
            cmd1(w ? 8'h06 : 8'h04);
            for (int k = 0; k < 3; k++) mem_wr(pa[k], 1, 8'hC0 + 8'(c * 8 + w * 4 + k));
            for (int k = 0; k < 3; k++) mem_rd_chk(pa[k], 1, "R7 protect sweep");
         end
      end
      stat_wr(8'h00);
      cmd1(8'h06);

      // R8: page wrap on write
      mem_wr(16'h2180, 1, 8'h99);
      mem_wr(16'h217E, 4, 8'h40);
      mem_rd_chk(16'h217E, 2, "R8 page tail");
      mem_rd_chk(16'h2100, 2, "R8 page wrap head");
      mem_rd_chk(16'h2180, 1, "R8 next page untouched");

      // R9: sequential read across 0xFFFF -> 0x0000
      mem_wr(16'hFFFE, 2, 8'h71);
      mem_wr(16'h0000, 2, 8'h73);
      mem_rd_chk(16'hFFFE, 4, "R9 read wrap");

      // R4: unknown instruction parks with output high
      cs_lo();
      xbyte(8'hAB, r);
      xbyte(8'h00, r);
      chk("R4 unknown opcode output", r, 8'hFF);
      cs_hi();
      mem_rd_chk(16'h0040, 1, "R4 after unknown opcode");

      // R1: chip select aborts a read mid address
      cs_lo();
      xbyte(8'h03, r);
      xbyte(8'h00, r);
      csn = 1'b1;
      tick(8);
      chk("R1 miso after abort", {7'b0, miso}, 8'h01);
      mem_rd_chk(16'hFFFF, 2, "R1 command after abort");

      // R2: hold pauses an instruction, edges during hold are ignored
      cs_lo();
      for (int i = 7; i >= 4; i--) sbit(1'b0, b);
      hold_n = 1'b0;
      tick(6);
      for (int i = 0; i < 3; i++) sbit(1'b1, b);
      csn = 1'b1;
      tick(6);
      csn = 1'b0;
      tick(6);
      hold_n = 1'b1;
      tick(6);
      sbit(1'b0, b); sbit(1'b0, b); sbit(1'b1, b); sbit(1'b1, b);
      xbyte(8'h00, r);
      xbyte(8'h41, r);
      xbyte(8'h00, r);
      chk("R2 read after hold", r, mdl[10'h041]);
      cs_hi();

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule